// File: doc/BRIEF.md
# Transmit Frame Buffer Formatter

This block turns one outgoing Ethernet frame, given as a requested length and a byte stream, into the image a MAC reads from a 16-bit packet buffer. It writes that image through a word port whose byte address starts at zero and advances by two with every write. The layout has four parts, in this order: a zero status word, a byte-count word, the payload packed two bytes to a word, and a closing control word.

Frames shorter than the Ethernet minimum are padded with zero bytes, which the block makes itself instead of taking them from the stream. When the padded length is odd, the last payload byte moves into the control word and a marker bit is set there. A request longer than the allowed maximum is rejected with an error pulse. A request made while a frame is in progress is ignored.

Top module: `tx_frame_formatter`

## Requirements
- R1: The frame length is the larger of `req_len` and MIN_LEN (default 60). Bytes at positions from `req_len` up to the frame length are zero and are not taken from the input stream. Exactly `req_len` bytes are consumed per accepted frame.
- R2: The first write of a frame goes to byte address 0 with data 0x0000. It appears in the first cycle that `busy` is high.
- R3: The second write goes to byte address 2 and carries the frame length plus 6.
- R4: Payload word k holds frame byte 2k in bits 7:0 and frame byte 2k+1 in bits 15:8, for k from 0 up to, but not including, floor(length/2).
- R5: Writes land on even byte addresses 0, 2, 4 and so on without gaps. A frame makes exactly 3 + floor(length/2) writes.
- R6: For an even frame length the control word, which is the last write, is 0x0000.
- R7: For an odd frame length the control word is 0x2000 OR'd with the final payload byte in bits 7:0. Bit 13 marks the odd byte.
- R8: `done` is high for one cycle, in the same cycle the control-word write is presented. `busy` is high from the cycle after an accepted `start` until that cycle, and is low in it.
- R9: `start` is ignored while `busy` is high. It does not change the frame in progress and produces no additional `done`.
- R10: A `start` with `req_len` above MAX_LEN raises `err` for one cycle, in the cycle after `start`. It writes nothing, consumes no bytes and leaves `busy` low.
- R11: A byte moves only when `in_valid` and `in_ready` are both high. When `in_valid` is low, the frame pauses and its contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to format one frame |
| req_len | input | LEN_W | Requested frame length in bytes |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block takes the payload byte this cycle |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Pulse marking the control-word write |
| err | output | 1 | Pulse marking a rejected oversize request |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer byte address |
| wr_data | output | 16 | Buffer write word |

## Verification
The bench builds the block with MAX_LEN set to 100 and ADDR_W set to 8, and keeps MIN_LEN at 60 and LEN_W at 11. With a maximum this small, the accepted limit of 100 and the rejected length of 101 both take only a few dozen cycles. Odd frames above the minimum, such as 61 and 99, exercise the control-word byte. Lengths of 0, 10 and 60 cover padding on either side of the minimum. With the 8-bit address, a whole frame image fits in a bench memory of 128 words.

// File: rtl/tx_frame_formatter.sv
module tx_frame_formatter #(
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 1518,
  parameter int ADDR_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data
);
  localparam logic [LEN_W-1:0]  MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0]  MAX_L = LEN_W'(MAX_LEN);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(2);

  typedef enum logic [1:0] {S_IDLE, S_CNT, S_PAY, S_CTL} st_t;
  st_t st;

  logic [LEN_W-1:0] rlen, flen, bidx;
  logic [7:0]       lo;

  wire [LEN_W-1:0] pad_len  = (req_len < MIN_L) ? MIN_L : req_len;
  wire [LEN_W-1:0] even_len = {flen[LEN_W-1:1], 1'b0};
  wire             feed     = bidx < rlen;
  wire             avail    = !feed || in_valid;
  wire [7:0]       cur      = feed ? in_data : 8'h00;

  assign busy     = (st != S_IDLE);
  assign in_ready = ((st == S_PAY) || (st == S_CTL)) && feed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rlen    <= '0;
      flen    <= '0;
      bidx    <= '0;
      lo      <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (req_len > MAX_L) begin
            err <= 1'b1;
          end else begin
            rlen    <= req_len;
            flen    <= pad_len;
            bidx    <= '0;
            wr_en   <= 1'b1;
            wr_addr <= '0;
            wr_data <= 16'h0000;
            st      <= S_CNT;
          end
        end
        S_CNT: begin
          wr_en   <= 1'b1;
          wr_addr <= wr_addr + STEP;
          wr_data <= 16'(flen) + 16'd6;
          st      <= S_PAY;
        end
        S_PAY: if (avail) begin
          bidx <= bidx + 1'b1;
          if (!bidx[0]) begin
            lo <= cur;
          end else begin
            wr_en   <= 1'b1;
            wr_addr <= wr_addr + STEP;
            wr_data <= {cur, lo};
          end
          if (bidx + 1'b1 == even_len) st <= S_CTL;
        end
        S_CTL: begin
          if (!flen[0]) begin
            wr_en   <= 1'b1;
            wr_addr <= wr_addr + STEP;
            wr_data <= 16'h0000;
            done    <= 1'b1;
            st      <= S_IDLE;
          end else if (in_valid) begin
            bidx    <= bidx + 1'b1;
            wr_en   <= 1'b1;
            wr_addr <= wr_addr + STEP;
            wr_data <= {8'h20, in_data};
            done    <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_frame_formatter_chk.sv
module tx_frame_formatter_chk #(
  parameter int MIN_LEN = 60,
  parameter int ADDR_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data
);
  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_en && wr_addr == '0 && wr_data == 16'h0000); // R2
  AST_COUNT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> wr_en && wr_addr == ADDR_W'(2) && wr_data >= 16'(MIN_LEN + 6)); // R3
  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_addr[0]); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_WITH_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wr_en && !busy); // R8
  AST_CTL_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_data != 16'h0000) |-> wr_data[15:8] == 8'h20); // R7
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_en && !busy); // R10
  AST_TAKE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> busy); // R11
endmodule

bind tx_frame_formatter tx_frame_formatter_chk #(.MIN_LEN(MIN_LEN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .busy(busy),
  .done(done), .err(err), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

// File: tb/sim_tx_frame_formatter.sv
module sim_tx_frame_formatter;
  localparam int LEN_W = 11, MIN_LEN = 60, MAX_LEN = 100, ADDR_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] in_data = '0;
  logic in_ready, busy, done, err, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [15:0] wr_data;

  always #4 clk = ~clk;

  tx_frame_formatter #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_len(req_len), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .busy(busy), .done(done), .err(err),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  int checks = 0, fails = 0;
  logic [7:0] src [0:255];
  logic [15:0] mem [0:127];
  int sidx = 0, wcount = 0, addr_bad = 0, donecnt = 0, cyc = 0;
  logic [ADDR_W-1:0] exp_addr = '0;
  logic clr = 1'b0, stall = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin
      sidx <= 0; wcount <= 0; addr_bad <= 0; donecnt <= 0; exp_addr <= '0;
    end else begin
      if (in_valid && in_ready) sidx <= sidx + 1;
      if (done) donecnt <= donecnt + 1;
      if (wr_en) begin
        mem[wr_addr[ADDR_W-1:1]] <= wr_data;
        wcount <= wcount + 1;
        if (wr_addr != exp_addr) addr_bad <= addr_bad + 1;
        exp_addr <= exp_addr + ADDR_W'(2);
      end
    end
  end

  always @(negedge clk) begin
    in_valid <= stall ? (cyc % 3 != 2) : 1'b1;
    in_data  <= src[sidx[7:0]];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prep(input int len, input bit st);
    for (int i = 0; i < 256; i++) src[i] = 8'(i * 13 + len + 1);
    for (int i = 0; i < 128; i++) mem[i] = 16'hdead;
    stall = st;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk); start = 1'b1; req_len = LEN_W'(len);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, req, 0, 1);
    if (seen) begin
      chk(!busy && wr_en, "R8 busy low with done", busy, 0);
      @(negedge clk);
      chk(!done, "R8 done single cycle", done, 0);
    end
  endtask

  task automatic check_frame(input int len);
    int fl, nw, bad;
    fl = (len < MIN_LEN) ? MIN_LEN : len;
    nw = fl / 2;
    repeat (2) @(negedge clk);
    chk(mem[0] == 16'h0000, "R2 status word", mem[0], 0);
    chk(mem[1] == 16'(fl + 6), "R3 count word", mem[1], fl + 6);
    bad = 0;
    for (int k = 0; k < nw; k++) begin
      logic [7:0] b0, b1;
      b0 = (2*k < len) ? src[2*k] : 8'h00;
      b1 = (2*k+1 < len) ? src[2*k+1] : 8'h00;
      if (mem[k+2] != {b1, b0}) bad++;
    end
    chk(bad == 0, "R4 R1 payload words", bad, 0);
    if (fl % 2 == 0)
      chk(mem[nw+2] == 16'h0000, "R6 even control", mem[nw+2], 0);
    else
      chk(mem[nw+2] == (16'h2000 | 16'(src[fl-1])), "R7 odd control", mem[nw+2], 16'h2000 | 16'(src[fl-1]));
    chk(wcount == 3 + nw && addr_bad == 0, "R5 write count and addresses", wcount, 3 + nw);
    chk(sidx == len, "R1 R11 bytes consumed", sidx, len);
    chk(donecnt == 1, "R8 one done", donecnt, 1);
  endtask

  task automatic run_frame(input int len, input bit st);
    prep(len, st);
    pulse_start(len);
    wait_done("R8 done seen");
    check_frame(len);
  endtask

  task automatic test_reset();
    chk(!busy && !done && !err && !wr_en && !in_ready, "R8 reset idle", {busy, done, err, wr_en}, 0);
  endtask

  task automatic test_oversize();
    prep(MAX_LEN + 1, 1'b0);
    @(negedge clk); start = 1'b1; req_len = LEN_W'(MAX_LEN + 1);
    @(negedge clk); start = 1'b0;
    chk(err && !wr_en && !busy, "R10 err pulse", {err, wr_en, busy}, 3'b100);
    @(negedge clk);
    chk(!err, "R10 err single cycle", err, 0);
    repeat (20) @(negedge clk);
    chk(wcount == 0 && sidx == 0 && !busy, "R10 nothing written", wcount, 0);
  endtask

  task automatic test_busy_start();
    prep(70, 1'b1);
    pulse_start(70);
    repeat (10) @(negedge clk);
    chk(busy, "R8 busy mid frame", busy, 1);
    start = 1'b1; req_len = LEN_W'(20);
    @(negedge clk); start = 1'b0;
    wait_done("R9 done seen");
    check_frame(70);
    repeat (30) @(negedge clk);
    chk(donecnt == 1 && !busy && wcount == 38, "R9 start ignored while busy", donecnt, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_frame(10, 1'b0);
    run_frame(0, 1'b0);
    run_frame(60, 1'b0);
    run_frame(61, 1'b0);
    run_frame(99, 1'b1);
    run_frame(MAX_LEN, 1'b1);
    test_oversize();
    test_busy_start();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule